// File: doc/BRIEF.md
# Channel Mode and Signaling Controller

This block decides, once per frame and separately for two voice channels (X and Y), the operating mode that the compression or expansion datapath uses for the next sample. The mode covers the coding rate (32, 24 or 16 kbps), the coding direction, the companding law, bypass and idle. In software mode these settings come from a per-channel configuration word. In hardware mode the configuration words are ignored and the settings come from strapped pins. The rate in hardware mode comes from a pair of pins whose timing after reset picks between the three rates.

The block watches each channel's frame sync, which is sampled on a bit-clock enable. A sync pulse that is high for two or more bit periods marks a signaling frame. For that frame, a channel programmed for 32 kbps runs at 24 kbps so that the freed low bit can carry signaling. The mode is latched when the frame sync falls, so a new setting takes effect from the next sample without a reset. The block also gives the value of the filler bit that follows the LSB of a 24 kbps code, and a standby flag that is set when both channels are idle.

There is no data stream through this block. Each channel has an update strobe that is a plain one-cycle pulse with no ready signal. The datapath must take the new mode in the cycle the strobe is high, because nothing holds it back.

Top module: `chmode_ctrl`

## Requirements
- R1: In software mode the rate field (mode[5:4]: 0 = 32 kbps, 1 = 24 kbps, 2 = 16 kbps) is decoded from the algorithm code cfg[6:4]. Code 3'b000 gives 32 kbps, 3'b111 gives 24 kbps and 3'b101 gives 16 kbps. Every other code gives 32 kbps.
- R2: A channel's mode output changes only when that channel's frame sync falls on a bit tick. A configuration change between frames has no effect until the next falling edge.
- R3: A frame sync that is high for two or more bit ticks on a channel whose selected rate is 32 kbps gives rate 24 kbps and sets the signaling flag mode[6]. A sync that is high for one tick, or any sync on a 24 or 16 kbps channel, leaves the rate unchanged and clears mode[6].
- R4: In hardware mode (sw_mode low), cfg_x and cfg_y are ignored and bypass mode[2] is 0. X takes encode from hw_strap[0] and the law from hw_strap[2]. Y takes encode from hw_strap[3] and the law from hw_strap[5]. Idle comes from hw_idle_x and hw_idle_y. Output field order is mode[3] idle, mode[1] law (1 = mu-law), mode[0] encode (1 = compress).
- R5: In hardware mode, the rate pins hw_strap[1] and hw_strap[4] select the rate. If both are high on the first clock after reset release, the rate is 16 kbps. If they are low, the rate is 32 kbps.
- R6: In hardware mode, after both rate pins are seen low at reset release, they go high together and the rate becomes 24 kbps until the next reset, provided the rise comes at least ARM_CYC clocks after release. An earlier rise keeps 32 kbps until the next reset.
- R7: The filler bit mode[7] is 1 only in software mode with encode set and an algorithm code that decodes to 24 kbps. It is 0 for a 24 kbps rate reached through signaling and in hardware mode.
- R8: standby is high exactly when the latched idle bits of both channels are high.
- R9: After reset, both mode outputs read 8'h08 (32 kbps, idle), standby is high and both strobes are low.
- R10: Each frame-sync fall produces exactly one single-cycle pulse on that channel's update strobe, in the clock after the mode is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | Bit-clock enable; frame syncs are sampled when high |
| sw_mode | input | 1 | 1 = settings from cfg words, 0 = settings from strap pins |
| cfg_x | input | 7 | X config: [6:4] algorithm code, [3] idle, [2] bypass, [1] law, [0] encode |
| cfg_y | input | 7 | Y config, same layout |
| hw_strap | input | 6 | Strap pins used in hardware mode |
| hw_idle_x | input | 1 | X idle strap |
| hw_idle_y | input | 1 | Y idle strap |
| fs_x | input | 1 | X frame sync |
| fs_y | input | 1 | Y frame sync |
| mode_x | output | 8 | X mode: [7] filler bit, [6] signaling, [5:4] rate, [3] idle, [2] bypass, [1] law, [0] encode |
| mode_y | output | 8 | Y mode, same layout |
| upd_x | output | 1 | X mode update strobe |
| upd_y | output | 1 | Y mode update strobe |
| standby | output | 1 | Both channels idle |

## Verification
The assertions assume that a frame sync never falls on two bit ticks in a row. A fall needs a high tick followed by a low tick, so two strobes from one channel are always at least two ticks apart. They also assume that sw_mode changes only around a reset, so the hardware-mode bypass check can look at the previous cycle's sw_mode. The bench drives frame syncs only as whole bit periods of two clocks each, with at least three low bits between pulses. It switches sw_mode only while reset is asserted and moves the strap pins only between frames.

// File: rtl/chmode_pkg.sv
package chmode_pkg;

  typedef enum logic [1:0] {
    RATE32 = 2'd0,
    RATE24 = 2'd1,
    RATE16 = 2'd2
  } rate_e;

  // settings offered by the selected source, before per-frame adjustment
  typedef struct packed {
    rate_e rate;
    logic  idle;
    logic  bypass;
    logic  mulaw;
    logic  encode;
  } chan_src_t;

  // latched per-frame mode
  typedef struct packed {
    logic  pad;
    logic  sig;
    rate_e rate;
    logic  idle;
    logic  bypass;
    logic  mulaw;
    logic  encode;
  } chan_mode_t;

  localparam chan_mode_t MODE_RST = '{pad: 1'b0, sig: 1'b0, rate: RATE32,
                                      idle: 1'b1, bypass: 1'b0,
                                      mulaw: 1'b0, encode: 1'b0};

endpackage

// File: rtl/chmode_alg_dec.sv
module chmode_alg_dec
  import chmode_pkg::*;
(
  input  logic [2:0] alg,
  output rate_e      rate
);

  always_comb begin
    case (alg)
      3'b111:  rate = RATE24;
      3'b101:  rate = RATE16;
      default: rate = RATE32;
    endcase
  end

endmodule

// File: rtl/chmode_hw_strap.sv
module chmode_hw_strap
  import chmode_pkg::*;
#(
  parameter int ARM_CYC = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_a,
  input  logic  pin_b,
  output rate_e rate
);

  localparam int CW = $clog2(ARM_CYC + 1);
  localparam logic [CW-1:0] ARM_V = CW'(ARM_CYC);

  typedef enum logic [2:0] {
    S_INIT, S_WAIT, S_LOCK32, S_R24, S_R16
  } st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  logic          both_hi;

  assign both_hi = pin_a & pin_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_INIT;
      cnt <= '0;
    end else begin
      case (st)
        S_INIT: st <= both_hi ? S_R16 : S_WAIT;
        S_WAIT: begin
          if (cnt != ARM_V) cnt <= cnt + CW'(1);
          if (both_hi) st <= (cnt == ARM_V) ? S_R24 : S_LOCK32;
        end
        default: st <= st;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_R24:   rate = RATE24;
      S_R16:   rate = RATE16;
      default: rate = RATE32;
    endcase
  end

  AST_EARLY_RISE_KEEPS_32: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && both_hi && cnt != ARM_V) |=> (rate == RATE32)); // R6

  AST_STRAP_HIGH_GIVES_16: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INIT && both_hi) |=> (rate == RATE16)); // R5

endmodule

// File: rtl/chmode_fs_det.sv
module chmode_fs_det #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fs,
  output logic evt,
  output logic wide
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             fs_q;
  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      hi_cnt <= '0;
    end else if (tick) begin
      fs_q <= fs;
      if (!fs)                   hi_cnt <= '0;
      else if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + CNT_W'(1);
    end
  end

  assign evt  = tick & fs_q & ~fs;
  assign wide = (hi_cnt >= CNT_W'(2));

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (hi_cnt != '0)); // R3

endmodule

// File: rtl/chmode_chan_latch.sv
module chmode_chan_latch
  import chmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       wide,
  input  logic       sw_mode,
  input  chan_src_t  src,
  output chan_mode_t mode,
  output logic       upd
);

  logic steal;
  assign steal = wide && (src.rate == RATE32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RST;
      upd  <= 1'b0;
    end else begin
      upd <= evt;
      if (evt) begin
        mode.rate   <= steal ? RATE24 : src.rate;
        mode.sig    <= steal;
        mode.pad    <= sw_mode && src.encode && (src.rate == RATE24);
        mode.idle   <= src.idle;
        mode.bypass <= src.bypass;
        mode.mulaw  <= src.mulaw;
        mode.encode <= src.encode;
      end
    end
  end

  AST_SIG_RUNS_24: assert property (@(posedge clk) disable iff (!rst_n)
    mode.sig |-> (mode.rate == RATE24)); // R3

  AST_PAD_ONLY_PROGRAMMED_24: assert property (@(posedge clk) disable iff (!rst_n)
    mode.pad |-> (mode.encode && mode.rate == RATE24 && !mode.sig)); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(mode)); // R2

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd); // R10

endmodule

// File: rtl/chmode_ctrl.sv
module chmode_ctrl
  import chmode_pkg::*;
#(
  parameter int ARM_CYC = 16,
  parameter int FS_CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       sw_mode,
  input  logic [6:0] cfg_x,
  input  logic [6:0] cfg_y,
  input  logic [5:0] hw_strap,
  input  logic       hw_idle_x,
  input  logic       hw_idle_y,
  input  logic       fs_x,
  input  logic       fs_y,
  output logic [7:0] mode_x,
  output logic [7:0] mode_y,
  output logic       upd_x,
  output logic       upd_y,
  output logic       standby
);

  localparam int NCH = 2;
  localparam int PINS_PER_CH = 3;

  rate_e      hw_rate;
  logic [6:0] cfg_a  [NCH];
  logic       fs_a   [NCH];
  logic       hidl_a [NCH];
  chan_mode_t mode_a [NCH];
  logic       upd_a  [NCH];

  assign cfg_a[0]  = cfg_x;
  assign cfg_a[1]  = cfg_y;
  assign fs_a[0]   = fs_x;
  assign fs_a[1]   = fs_y;
  assign hidl_a[0] = hw_idle_x;
  assign hidl_a[1] = hw_idle_y;

  chmode_hw_strap #(.ARM_CYC(ARM_CYC)) u_strap (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_a (hw_strap[1]),
    .pin_b (hw_strap[4]),
    .rate  (hw_rate)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rate_e     sw_rate;
    chan_src_t src;
    logic      evt, wide;

    chmode_alg_dec u_dec (
      .alg  (cfg_a[c][6:4]),
      .rate (sw_rate)
    );

    always_comb begin
      if (sw_mode) begin
        src.rate   = sw_rate;
        src.idle   = cfg_a[c][3];
        src.bypass = cfg_a[c][2];
        src.mulaw  = cfg_a[c][1];
        src.encode = cfg_a[c][0];
      end else begin
        src.rate   = hw_rate;
        src.idle   = hidl_a[c];
        src.bypass = 1'b0;
        src.mulaw  = hw_strap[c*PINS_PER_CH + 2];
        src.encode = hw_strap[c*PINS_PER_CH];
      end
    end

    chmode_fs_det #(.CNT_W(FS_CNT_W)) u_fs (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (bit_tick),
      .fs    (fs_a[c]),
      .evt   (evt),
      .wide  (wide)
    );

    chmode_chan_latch u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .wide    (wide),
      .sw_mode (sw_mode),
      .src     (src),
      .mode    (mode_a[c]),
      .upd     (upd_a[c])
    );
  end

  assign mode_x  = mode_a[0];
  assign mode_y  = mode_a[1];
  assign upd_x   = upd_a[0];
  assign upd_y   = upd_a[1];
  assign standby = mode_a[0].idle & mode_a[1].idle;

  AST_HW_NO_BYPASS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_x && !$past(sw_mode)) |-> !mode_x[2]); // R4

  AST_HW_NO_BYPASS_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_y && !$past(sw_mode)) |-> !mode_y[2]); // R4

endmodule

// File: tb/sim_chmode_ctrl.sv
module sim_chmode_ctrl;

  localparam int ARM = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       sw_mode = 1'b1;
  logic [6:0] cfg_x = '0, cfg_y = '0;
  logic [5:0] hw_strap = '0;
  logic       hw_idle_x = 1'b0, hw_idle_y = 1'b0;
  logic       fs_x = 1'b0, fs_y = 1'b0;
  logic [7:0] mode_x, mode_y;
  logic       upd_x, upd_y, standby;

  int vectors = 0;
  int miscompares = 0;
  int upd_cnt_x = 0;
  int upd_cnt_y = 0;

  chmode_ctrl #(.ARM_CYC(ARM), .FS_CNT_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sw_mode(sw_mode),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .hw_strap(hw_strap),
    .hw_idle_x(hw_idle_x), .hw_idle_y(hw_idle_y),
    .fs_x(fs_x), .fs_y(fs_y), .mode_x(mode_x), .mode_y(mode_y),
    .upd_x(upd_x), .upd_y(upd_y), .standby(standby)
  );

  always #10 clk = ~clk;
  always @(posedge clk) bit_tick <= ~bit_tick;
  always @(posedge clk) begin
    if (upd_x) upd_cnt_x <= upd_cnt_x + 1;
    if (upd_y) upd_cnt_y <= upd_cnt_y + 1;
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bit_step();
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input bit dox, input bit doy, input int w);
    fs_x = dox;
    fs_y = doy;
    repeat (w) bit_step();
    fs_x = 1'b0;
    fs_y = 1'b0;
    repeat (3) bit_step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_sw(input logic [6:0] cfg, input bit wide);
    logic [1:0] base;
    logic [1:0] rate;
    logic       sig, pad;
    base = (cfg[6:4] == 3'b111) ? 2'd1 : (cfg[6:4] == 3'b101) ? 2'd2 : 2'd0;
    sig  = wide && (base == 2'd0);
    rate = sig ? 2'd1 : base;
    pad  = cfg[0] && (base == 2'd1);
    return {pad, sig, rate, cfg[3:0]};
  endfunction

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int before_x;
    logic [7:0] held;
    repeat (2) @(negedge clk);
    do_reset();
    @(negedge clk);
    // R9: reset state
    chk("R9 mode_x reset", mode_x, 8'h08);
    chk("R9 mode_y reset", mode_y, 8'h08);
    chk("R9 standby reset", {7'b0, standby}, 8'h01);
    chk("R9 strobes reset", {6'b0, upd_x, upd_y}, 8'h00);

    // R1/R3/R7: sweep algorithm code, encode and pulse width on both channels
    for (int a = 0; a < 8; a++) begin
      for (int e = 0; e < 2; e++) begin
        for (int w = 1; w <= 3; w++) begin
          cfg_x = {3'(a), 1'b0, 1'(w == 3), 1'(a[0]), 1'(e)};
          cfg_y = {3'(7 - a), 1'(e), 1'b0, 1'(w == 2), 1'(~e)};
          frame(1'b1, 1'b1, w);
          chk($sformatf("R1 R3 R7 x alg=%0d enc=%0d w=%0d", a, e, w), mode_x, exp_sw(cfg_x, w >= 2));
          chk($sformatf("R1 R3 R7 y alg=%0d enc=%0d w=%0d", 7 - a, ~e, w), mode_y, exp_sw(cfg_y, w >= 2));
        end
      end
    end

    // R2: mid-frame config change has no effect until the next frame
    cfg_x = 7'b101_0011;
    frame(1'b1, 1'b0, 1);
    held = mode_x;
    chk("R2 first frame", held, exp_sw(7'b101_0011, 1'b0));
    cfg_x = 7'b111_0101;
    repeat (6) bit_step();
    chk("R2 held between frames", mode_x, held);
    frame(1'b1, 1'b0, 1);
    chk("R2 applied at next frame", mode_x, exp_sw(7'b111_0101, 1'b0));

    // R10: one strobe per frame
    before_x = upd_cnt_x;
    frame(1'b1, 1'b0, 2);
    chk("R10 strobe count x", 8'(upd_cnt_x - before_x), 8'd1);

    // R8: standby
    cfg_x = 7'b000_1000; cfg_y = 7'b000_1000;
    frame(1'b1, 1'b1, 1);
    chk("R8 both idle", {7'b0, standby}, 8'h01);
    cfg_y = 7'b000_0000;
    frame(1'b1, 1'b1, 1);
    chk("R8 one idle", {7'b0, standby}, 8'h00);

    // R4: hardware pin mapping sweep, config words ignored
    rst_n = 1'b0;
    sw_mode = 1'b0;
    cfg_x = 7'h7F; cfg_y = 7'h7F;
    hw_strap = '0;
    do_reset();
    for (int p = 0; p < 64; p++) begin
      hw_strap = {1'(p[3]), 1'b0, 1'(p[2]), 1'(p[1]), 1'b0, 1'(p[0])};
      hw_idle_x = p[4];
      hw_idle_y = p[5];
      frame(1'b1, 1'b1, 1);
      chk($sformatf("R4 x pins=%0d", p), mode_x, {4'b0000, 1'(p[4]), 1'b0, 1'(p[1]), 1'(p[0])});
      chk($sformatf("R4 y pins=%0d", p), mode_y, {4'b0000, 1'(p[5]), 1'b0, 1'(p[3]), 1'(p[2])});
    end

    // R5: pins low -> 32 kbps, with signaling still possible
    hw_idle_x = 1'b0; hw_idle_y = 1'b0;
    hw_strap = 6'b000001;
    frame(1'b1, 1'b0, 2);
    chk("R5 hw low wide", mode_x, 8'b0101_0001);

    // R5: pins high from reset -> 16 kbps
    rst_n = 1'b0;
    hw_strap = 6'b010010;
    do_reset();
    frame(1'b1, 1'b1, 2);
    chk("R5 hw high 16k", mode_x, 8'b0010_0000);

    // R6: late rise -> 24 kbps, no filler bit in hardware mode
    rst_n = 1'b0;
    hw_strap = 6'b000001;
    do_reset();
    repeat (ARM + 20) @(negedge clk);
    hw_strap = 6'b010011;
    frame(1'b1, 1'b0, 1);
    chk("R6 late rise 24k", mode_x, 8'b0001_0001);
    frame(1'b1, 1'b0, 2);
    chk("R6 R7 24k wide no sig no pad", mode_x, 8'b0001_0001);

    // R6: early rise -> stays 32 kbps
    rst_n = 1'b0;
    hw_strap = 6'b000000;
    do_reset();
    repeat (5) @(negedge clk);
    hw_strap = 6'b010010;
    frame(1'b1, 1'b0, 1);
    chk("R6 early rise keeps 32k", mode_x, 8'b0000_0000);
    repeat (ARM) @(negedge clk);
    frame(1'b1, 1'b0, 1);
    chk("R6 early rise locked", mode_x, 8'b0000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule